// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt Combiner

This block watches the current seconds, minutes, hours and day-of-month of a real-time clock, all in BCD, and compares them with four programmable alarm registers. Each alarm register carries a skip bit in its top position. Setting that bit leaves the field out of the comparison. This lets the alarm repeat every second, every minute, every hour or every day. The comparison runs only in the cycle where the time keeper reports an update on `time_upd`. A matching time therefore raises the alarm flag once per time change, and not on every clock while the time still matches.

The alarm flag sits in a small flags register next to a watchdog flag and a power-fail flag. Each of those is set by a one-cycle event input from its own source. Reading the flags register returns its contents and clears it. A control register holds one enable per source, an output polarity bit and a level/pulse select. The shared interrupt pin reflects every enabled flag. In level mode it stays active until software reads the flags. In pulse mode it is active for a fixed number of clocks after each enabled event. While `backup_mode` is high the pin stays inactive, but the flags are still recorded.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, the four alarm registers read 0x80, the control register reads 0x00, the flags register reads 0x00, and `irq_out` is high.
- R2: Register addresses are: 0 seconds alarm, 1 minutes alarm, 2 hours alarm, 3 date alarm, 4 control, 5 flags. Addresses 6 and 7 read 0x00. `reg_rdata` shows the addressed value on the cycle after `reg_rd`. Control bits: 7 watchdog enable, 6 alarm enable, 5 power-fail enable, 3 polarity, 2 pulse mode. The other control bits read 0.
- R3: An alarm field takes part in the comparison only when its bit 7 is 0. A participating field matches when its bits 6:0 equal bits 6:0 of the corresponding current-time input. The comparison is made only in a cycle with `time_upd` high.
- R4: When bit 7 is set in all four alarm registers, no alarm ever fires.
- R5: A match sets flags bit 0 from the following cycle on. A flags read returns the value before the clear and clears all flags. A flag set in the same cycle as the read survives.
- R6: A `wdog_evt` pulse sets flags bit 1, and a `pfail_evt` pulse sets flags bit 2.
- R7: Writes to the flags address have no effect.
- R8: A flag whose enable bit is 0 never activates `irq_out`, but the flag is still set.
- R9: In level mode (control bit 2 = 0), `irq_out` is active while any enabled flag is set. It goes inactive the cycle after the flags read.
- R10: In pulse mode (control bit 2 = 1), `irq_out` is active for exactly PULSE_CYCLES cycles, starting the cycle after an enabled event, whether or not the flags are read.
- R11: With control bit 3 = 1, the active level of `irq_out` is high. With bit 3 = 0, it is low.
- R12: While `backup_mode` is high, `irq_out` is held inactive and pulse mode starts no pulse. The flags are still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| time_upd | input | 1 | One-cycle strobe: current time just changed |
| wdog_evt | input | 1 | Watchdog expiry event |
| pfail_evt | input | 1 | Power-fail event |
| backup_mode | input | 1 | Running from backup supply; interrupts suppressed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the read |
| irq_out | output | 1 | Combined interrupt, programmable polarity |

## Verification
A wrong skip bit or a wrong compare shows up on the very next flags read. The flags read is one cycle late, and with the alarm enabled in level mode, `irq_out` is wrong one cycle after the `time_upd` strobe. A flag that fails to clear on read leaves `irq_out` active in level mode, and a second read then returns a nonzero value. A pulse counter that loads or counts wrong makes the pin change state in the wrong cycle, within PULSE_CYCLES+1 cycles of the event.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int NUM_FIELDS = 4;
   localparam int FIELD_W    = 8;
   localparam int SKIP_BIT   = FIELD_W - 1;
   localparam int NUM_FLAGS  = 3;

   localparam logic [2:0] ADR_SEC  = 3'd0;
   localparam logic [2:0] ADR_MIN  = 3'd1;
   localparam logic [2:0] ADR_HOUR = 3'd2;
   localparam logic [2:0] ADR_DATE = 3'd3;
   localparam logic [2:0] ADR_CTRL = 3'd4;
   localparam logic [2:0] ADR_FLAG = 3'd5;

   localparam int FLG_ALARM = 0;
   localparam int FLG_WDOG  = 1;
   localparam int FLG_PFAIL = 2;

   typedef struct packed {
      logic wdog_en;
      logic alarm_en;
      logic pfail_en;
      logic act_high;
      logic pulse_mode;
   } irq_ctrl_t;

   function automatic logic [FIELD_W-1:0] ctrl_to_byte(irq_ctrl_t c);
      return {c.wdog_en, c.alarm_en, c.pfail_en, 1'b0, c.act_high, c.pulse_mode, 2'b00};
   endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
   import rtc_alarm_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr,
   input  logic                                rd,
   input  logic [ADDR_W-1:0]                   addr,
   input  logic [FIELD_W-1:0]                  wdata,
   input  logic                                alarm_hit,
   input  logic                                wdog_evt,
   input  logic                                pfail_evt,
   output logic [FIELD_W-1:0]                  rdata,
   output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  alarm_q,
   output irq_ctrl_t                           ctrl_q,
   output logic [NUM_FLAGS-1:0]                flags_q
);
   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] flags_d;
   logic                 flag_read;
   logic [FIELD_W-1:0]   rd_mux;

   assign flag_read = rd && (addr == ADDR_W'(ADR_FLAG));

   always_comb begin
      set_vec            = '0;
      set_vec[FLG_ALARM] = alarm_hit;
      set_vec[FLG_WDOG]  = wdog_evt;
      set_vec[FLG_PFAIL] = pfail_evt;
      flags_d = (flag_read ? '0 : flags_q) | set_vec;
   end

   always_comb begin
      rd_mux = '0;
      if (addr < ADDR_W'(NUM_FIELDS))
         rd_mux = alarm_q[addr[1:0]];
      else if (addr == ADDR_W'(ADR_CTRL))
         rd_mux = ctrl_to_byte(ctrl_q);
      else if (addr == ADDR_W'(ADR_FLAG))
         rd_mux = FIELD_W'(flags_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FIELDS; i++)
            alarm_q[i] <= FIELD_W'(1) << SKIP_BIT;
         ctrl_q  <= '0;
         flags_q <= '0;
         rdata   <= '0;
      end else begin
         flags_q <= flags_d;
         if (rd) rdata <= rd_mux;
         if (wr) begin
            if (addr < ADDR_W'(NUM_FIELDS))
               alarm_q[addr[1:0]] <= wdata;
            else if (addr == ADDR_W'(ADR_CTRL))
               ctrl_q <= '{wdog_en:wdata[7], alarm_en:wdata[6], pfail_en:wdata[5],
                           act_high:wdata[3], pulse_mode:wdata[2]};
         end
      end
   end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alarm_pkg::*;
(
   input  logic                               time_upd,
   input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_q,
   input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur_time,
   output logic                               alarm_hit
);
   logic [NUM_FIELDS-1:0] in_use;
   logic [NUM_FIELDS-1:0] ok;

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      assign in_use[g] = ~alarm_q[g][SKIP_BIT];
      assign ok[g]     = ~in_use[g] ||
                         (alarm_q[g][SKIP_BIT-1:0] == cur_time[g][SKIP_BIT-1:0]);
   end

   assign alarm_hit = time_upd && (|in_use) && (&ok);
endmodule

// File: rtl/rtc_alarm_irq_drv.sv
module rtc_alarm_irq_drv
   import rtc_alarm_pkg::*;
#(
   parameter int PULSE_CYCLES = 8,
   localparam int CNT_W = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  irq_ctrl_t            ctrl_q,
   input  logic [NUM_FLAGS-1:0] flags_q,
   input  logic [NUM_FLAGS-1:0] evt_vec,
   input  logic                 backup_mode,
   output logic [CNT_W-1:0]     pulse_cnt,
   output logic                 irq_out
);
   logic [NUM_FLAGS-1:0] en_vec;
   logic                 start;
   logic                 level_act;
   logic                 active;

   always_comb begin
      en_vec            = '0;
      en_vec[FLG_ALARM] = ctrl_q.alarm_en;
      en_vec[FLG_WDOG]  = ctrl_q.wdog_en;
      en_vec[FLG_PFAIL] = ctrl_q.pfail_en;
   end

   assign start     = |(evt_vec & en_vec) && !backup_mode;
   assign level_act = |(flags_q & en_vec);

   if (PULSE_CYCLES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) pulse_cnt <= '0;
         else        pulse_cnt <= CNT_W'(start);
      end
   end else begin : g_count
      always_ff @(posedge clk) begin
         if (!rst_n)                pulse_cnt <= '0;
         else if (start)            pulse_cnt <= CNT_W'(PULSE_CYCLES);
         else if (pulse_cnt != '0)  pulse_cnt <= pulse_cnt - 1'b1;
      end
   end

   assign active  = !backup_mode &&
                    (ctrl_q.pulse_mode ? (pulse_cnt != '0) : level_act);
   assign irq_out = ctrl_q.act_high ? active : ~active;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_pkg::*;
#(
   parameter int ADDR_W       = 3,
   parameter int PULSE_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        cur_sec,
   input  logic [7:0]        cur_min,
   input  logic [7:0]        cur_hour,
   input  logic [7:0]        cur_date,
   input  logic              time_upd,
   input  logic              wdog_evt,
   input  logic              pfail_evt,
   input  logic              backup_mode,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata
,  output logic              irq_out
);
   localparam int CNT_W = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES + 1);

   initial begin
      assert (ADDR_W >= 3) else $error("ADDR_W must cover six registers");
      assert (PULSE_CYCLES >= 1) else $error("PULSE_CYCLES must be at least 1");
   end

   logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_q;
   logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur_time;
   irq_ctrl_t                          ctrl_q;
   logic [NUM_FLAGS-1:0]               flags_q;
   logic [NUM_FLAGS-1:0]               evt_vec;
   logic [CNT_W-1:0]                   pulse_cnt;
   logic                               alarm_hit;

   assign cur_time = {cur_date, cur_hour, cur_min, cur_sec};

   always_comb begin
      evt_vec            = '0;
      evt_vec[FLG_ALARM] = alarm_hit;
      evt_vec[FLG_WDOG]  = wdog_evt;
      evt_vec[FLG_PFAIL] = pfail_evt;
   end

   rtc_alarm_match match_i (
      .time_upd (time_upd),
      .alarm_q  (alarm_q),
      .cur_time (cur_time),
      .alarm_hit(alarm_hit)
   );

   rtc_alarm_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .rd       (reg_rd),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .alarm_hit(alarm_hit),
      .wdog_evt (wdog_evt),
      .pfail_evt(pfail_evt),
      .rdata    (reg_rdata),
      .alarm_q  (alarm_q),
      .ctrl_q   (ctrl_q),
      .flags_q  (flags_q)
   );

   rtc_alarm_irq_drv #(.PULSE_CYCLES(PULSE_CYCLES)) drv_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_q     (ctrl_q),
      .flags_q    (flags_q),
      .evt_vec    (evt_vec),
      .backup_mode(backup_mode),
      .pulse_cnt  (pulse_cnt),
      .irq_out    (irq_out)
   );
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk
   import rtc_alarm_pkg::*;
#(
   parameter int ADDR_W       = 3,
   parameter int PULSE_CYCLES = 8,
   parameter int CNT_W        = 4
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               reg_wr,
   input logic                               reg_rd,
   input logic [ADDR_W-1:0]                  reg_addr,
   input logic                               wdog_evt,
   input logic                               pfail_evt,
   input logic                               backup_mode,
   input logic                               irq_out,
   input logic                               alarm_hit,
   input logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_q,
   input irq_ctrl_t                          ctrl_q,
   input logic [NUM_FLAGS-1:0]               flags_q,
   input logic [CNT_W-1:0]                   pulse_cnt
);
   logic all_skip;
   assign all_skip = alarm_q[0][SKIP_BIT] && alarm_q[1][SKIP_BIT] &&
                     alarm_q[2][SKIP_BIT] && alarm_q[3][SKIP_BIT];

   // R4
   all_skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_skip |-> !alarm_hit);

   // R5
   alarm_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> flags_q[FLG_ALARM]);

   // R7
   flag_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(ADR_FLAG) && !reg_rd && !alarm_hit && !wdog_evt && !pfail_evt)
      |=> $stable(flags_q));

   // R10
   pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_cnt <= CNT_W'(PULSE_CYCLES));

   // R12
   backup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backup_mode |-> (irq_out == !ctrl_q.act_high));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(
   .ADDR_W(ADDR_W), .PULSE_CYCLES(PULSE_CYCLES), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .wdog_evt(wdog_evt), .pfail_evt(pfail_evt), .backup_mode(backup_mode),
   .irq_out(irq_out), .alarm_hit(alarm_hit), .alarm_q(alarm_q), .ctrl_q(ctrl_q),
   .flags_q(flags_q), .pulse_cnt(pulse_cnt)
);

// File: tb/rtc_alarm_irq_tb_top.sv
module rtc_alarm_irq_tb_top;
   localparam int PULSE = 8;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } rd_item_t;

   logic       clk = 0;
   logic       rst_n = 0;
   logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 0;
   logic       time_upd = 0, wdog_evt = 0, pfail_evt = 0, backup_mode = 0;
   logic       reg_wr = 0, reg_rd = 0;
   logic [2:0] reg_addr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic       irq_out;

   int n_chk = 0;
   int n_bad = 0;
   rd_item_t exp_q[$];
   logic rd_seen = 0;

   always #5 clk = ~clk;

   rtc_alarm_irq #(.ADDR_W(3), .PULSE_CYCLES(PULSE)) dut_i (
      .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .cur_min(cur_min),
      .cur_hour(cur_hour), .cur_date(cur_date), .time_upd(time_upd),
      .wdog_evt(wdog_evt), .pfail_evt(pfail_evt), .backup_mode(backup_mode),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   // monitor: pairs each read with its expected value
   always @(posedge clk) rd_seen <= reg_rd;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         rd_item_t it;
         it = exp_q.pop_front();
         n_chk++;
         if (reg_rdata !== it.exp) begin
            n_bad++;
            $display("FAIL %s: rdata actual %02h expected %02h", it.tag, reg_rdata, it.exp);
         end
      end
   end

   task automatic chk_irq(input logic exp, input string tag);
      n_chk++;
      if (irq_out !== exp) begin
         n_bad++;
         $display("FAIL %s: irq_out actual %b expected %b", tag, irq_out, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
      rd_item_t it;
      it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      reg_rd = 1; reg_addr = a;
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic tick(input logic [7:0] d, h, m, s);
      cur_date = d; cur_hour = h; cur_min = m; cur_sec = s;
      time_upd = 1;
      @(negedge clk);
      time_upd = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      fork
         begin
            repeat (20000) @(negedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
         end
         begin
            idle(3);
            rst_n = 1;
            idle(1);
            // R1 reset state
            chk_irq(1'b1, "R1 reset irq");
            rd(3'd0, 8'h80, "R1 sec alarm"); rd(3'd1, 8'h80, "R1 min alarm");
            rd(3'd2, 8'h80, "R1 hour alarm"); rd(3'd3, 8'h80, "R1 date alarm");
            rd(3'd4, 8'h00, "R1 ctrl"); rd(3'd5, 8'h00, "R1 flags");
            // R2 map and unused bits
            wr(3'd4, 8'hFF); rd(3'd4, 8'hEC, "R2 ctrl bits");
            rd(3'd6, 8'h00, "R2 addr6"); rd(3'd7, 8'h00, "R2 addr7");
            // level, active high, alarm enabled
            wr(3'd4, 8'h48);
            wr(3'd0, 8'h30);
            rd(3'd0, 8'h30, "R2 sec readback");
            chk_irq(1'b0, "R11 inactive high");
            tick(8'h01, 8'h02, 8'h03, 8'h31);
            chk_irq(1'b0, "R3 seconds mismatch");
            tick(8'h01, 8'h02, 8'h03, 8'hB0);
            chk_irq(1'b1, "R3 bit7 of time ignored, match");
            chk_irq(1'b1, "R9 level held");
            rd(3'd5, 8'h01, "R5 alarm flag");
            chk_irq(1'b0, "R9 cleared by read");
            rd(3'd5, 8'h00, "R5 flags cleared");
            // once per change: time held, no strobe
            cur_sec = 8'h30; idle(4);
            rd(3'd5, 8'h00, "R3 no strobe no fire");
            // full four-field match
            wr(3'd0, 8'h00); wr(3'd1, 8'h45); wr(3'd2, 8'h08); wr(3'd3, 8'h15);
            tick(8'h15, 8'h08, 8'h44, 8'h00);
            rd(3'd5, 8'h00, "R3 minutes mismatch");
            tick(8'h15, 8'h08, 8'h45, 8'h00);
            rd(3'd5, 8'h01, "R3 full match");
            // R4 all skipped
            wr(3'd0, 8'h80); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
            tick(8'h15, 8'h08, 8'h45, 8'h00);
            chk_irq(1'b0, "R4 all skipped irq");
            rd(3'd5, 8'h00, "R4 all skipped flag");
            // R8 disabled source
            wr(3'd0, 8'h10); wr(3'd4, 8'h08);
            tick(8'h00, 8'h00, 8'h00, 8'h10);
            chk_irq(1'b0, "R8 alarm disabled");
            rd(3'd5, 8'h01, "R8 flag still set");
            // R6 watchdog and power fail
            wr(3'd4, 8'h88);
            wdog_evt = 1; @(negedge clk); wdog_evt = 0;
            chk_irq(1'b1, "R6 watchdog irq");
            wr(3'd4, 8'h28);
            pfail_evt = 1; @(negedge clk); pfail_evt = 0;
            // R7 flag write ignored
            wr(3'd5, 8'h00);
            rd(3'd5, 8'h06, "R6 R7 wdog+pfail flags");
            wr(3'd5, 8'h07);
            rd(3'd5, 8'h00, "R7 write ignored");
            // R11 active low
            wr(3'd4, 8'h40);
            chk_irq(1'b1, "R11 inactive low");
            tick(8'h00, 8'h00, 8'h00, 8'h10);
            chk_irq(1'b0, "R11 active low asserted");
            rd(3'd5, 8'h01, "R11 flag");
            chk_irq(1'b1, "R11 released");
            // R10 pulse mode
            wr(3'd4, 8'h4C);
            tick(8'h00, 8'h00, 8'h00, 8'h10);
            chk_irq(1'b1, "R10 pulse first cycle");
            rd(3'd5, 8'h01, "R10 flag");
            chk_irq(1'b1, "R10 pulse survives read");
            idle(PULSE - 2);
            chk_irq(1'b1, "R10 pulse last cycle");
            idle(1);
            chk_irq(1'b0, "R10 pulse ended");
            // R12 backup mode
            wr(3'd4, 8'h48);
            backup_mode = 1;
            tick(8'h00, 8'h00, 8'h00, 8'h10);
            chk_irq(1'b0, "R12 backup suppressed");
            backup_mode = 0;
            #1 chk_irq(1'b1, "R12 level after backup");
            @(negedge clk);
            rd(3'd5, 8'h01, "R12 flag recorded");
            wr(3'd4, 8'h4C);
            backup_mode = 1;
            tick(8'h00, 8'h00, 8'h00, 8'h10);
            backup_mode = 0;
            #1 chk_irq(1'b0, "R12 no pulse started");
            @(negedge clk);
            rd(3'd5, 8'h01, "R12 flag in pulse mode");
            idle(2);
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule